// File: doc/BRIEF.md
# Security lock tamper-erase controller

This block guards the secret state of a secure loader subsystem: a lock bit, a multi-byte key register and a small on-chip vector store. A loader asks it to set or clear the lock, to load a key and to reach external program/data SRAM. An external tamper detector drives an active-high self-destruct line. A random byte source feeds a pool that supplies every new key.

Clearing the lock, or a qualified self-destruct pulse, starts an erase chain that nothing can stop. In the trigger cycle the key, the vector store and the lock are cleared together. The controller then takes the SRAM write port and writes zero to each address of the erase window in ascending order, one per cycle. Next it collects eight fresh random bytes and loads them as the new key. A self-destruct trigger also pulses a supply-kill output for the external memory. While the lock is set, the loader gets no access to the SRAM or to the vector store.

Top module: `sec_lock_ctrl`

## Requirements
- R1: After reset, lock_o, busy_o, supply_kill_o and key_o are all zero, access_o is 1, and the vector store reads zero.
- R2: A trigger taken while idle clears key_o, every vector byte and lock_o on the clock edge that raises busy_o. A trigger is unlock_req_i high, or an accepted self-destruct pulse.
- R3: From the cycle busy_o rises, the SRAM port writes 0x00 to addresses 0 through ERASE_WORDS-1 in ascending order, one address per cycle, with sram_cs_o and sram_we_o high.
- R4: After the zeroing, the next eight rnd_valid_i bytes form the new key, with the first byte in bits [63:56] and the last in bits [7:0]. busy_o falls on the edge that loads that key.
- R5: sdi_i passes a two-flop synchronizer. A high pulse lasting fewer than REJECT_CYC consecutive clock samples has no effect. A high pulse of ACCEPT_CYC or more samples triggers an erase.
- R6: A self-destruct trigger holds supply_kill_o high for exactly KILL_CYC cycles, starting in the cycle busy_o rises. An unlock trigger leaves supply_kill_o low.
- R7: lock_req_i sets lock_o when idle. While lock_o is 1, access_o is 0, sram_cs_o stays low for loader requests, and ld_rdata_o reads zero.
- R8: While busy_o is 1, lock, unlock, self-destruct, session-start, rekey and vector-write inputs have no effect. The erase runs to completion, lock_o stays 0, and supply_kill_o is not retriggered.
- R9: session_start_i empties the random pool. The first rekey_req_i that arrives when idle, unlocked and with eight pooled bytes loads the pool into key_o. Later rekey requests leave the key unchanged until the next session start. The erase reload also counts as the session's key.
- R10: vec_we_i writes vec_wdata_i at vec_waddr_i only when idle and unlocked. vec_rdata_o returns the byte at vec_raddr_i.
- R11: When idle and unlocked, access_o is 1 and loader requests pass straight through to the SRAM port. ld_rdata_o then returns sram_rdata_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lock_req_i | input | 1 | Request to set the lock |
| unlock_req_i | input | 1 | Request to clear the lock; starts the erase chain |
| sdi_i | input | 1 | Asynchronous self-destruct line, active high |
| session_start_i | input | 1 | Loader session begins; empties the pool and allows one rekey |
| rekey_req_i | input | 1 | Key reload request from a key-loading command |
| rnd_valid_i | input | 1 | Random byte strobe |
| rnd_byte_i | input | 8 | Random byte |
| vec_we_i | input | 1 | Vector store write enable |
| vec_waddr_i | input | VEC_AW | Vector store write address |
| vec_wdata_i | input | 8 | Vector store write data |
| vec_raddr_i | input | VEC_AW | Vector store read address |
| vec_rdata_o | output | 8 | Vector store read data |
| ld_req_i | input | 1 | Loader SRAM access request |
| ld_we_i | input | 1 | Loader access is a write |
| ld_addr_i | input | SRAM_AW | Loader SRAM address |
| ld_wdata_i | input | 8 | Loader write data |
| ld_rdata_o | output | 8 | Read data returned to the loader |
| sram_cs_o | output | 1 | SRAM chip select |
| sram_we_o | output | 1 | SRAM write enable |
| sram_addr_o | output | SRAM_AW | SRAM address |
| sram_wdata_o | output | 8 | SRAM write data |
| sram_rdata_i | input | 8 | SRAM read data |
| supply_kill_o | output | 1 | Removes supply from the external memory |
| lock_o | output | 1 | Lock state |
| busy_o | output | 1 | Erase chain running |
| access_o | output | 1 | Loader access allowed |
| key_o | output | 8*KEY_BYTES | Current key |

## Verification
The bench injects lock, unlock and a long self-destruct pulse in the middle of an erase. A design that let any of them through would re-arm the lock, restart the address walk or pulse the supply kill a second time. It sends self-destruct pulses on both sides of the deglitch window. A filter with the wrong threshold would either erase on a glitch or miss a real tamper. It also follows a consumed rekey with fresh random bytes and a second rekey request, so a missing once-per-session rule shows up as a changed key. It checks that the first pooled byte lands in the top byte of the key, which catches a reversed shift order.

// File: rtl/sec_lock_pkg.sv
package sec_lock_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WIPE = 2'd1,
    ST_SEED = 2'd2
  } erase_st_e;
endpackage

// File: rtl/sec_sdi_filter.sv
module sec_sdi_filter #(
  parameter int REJECT_CYC = 4,
  parameter int ACCEPT_CYC = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sdi_i,
  output logic trig_o
);
  localparam int CW = $clog2(ACCEPT_CYC + 1);

  logic          sync1_q, sync2_q;
  logic [CW-1:0] hi_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync1_q  <= 1'b0;
      sync2_q  <= 1'b0;
      hi_cnt_q <= '0;
    end else begin
      sync1_q <= sdi_i;
      sync2_q <= sync1_q;
      if (sync2_q) begin
        if (hi_cnt_q != CW'(ACCEPT_CYC)) hi_cnt_q <= hi_cnt_q + 1'b1;
      end else begin
        hi_cnt_q <= '0;
      end
    end
  end

  // fire once at the accept limit, or at the falling edge of a mid-length pulse
  always_comb begin
    trig_o = (sync2_q && hi_cnt_q == CW'(ACCEPT_CYC - 1)) ||
             (!sync2_q && hi_cnt_q >= CW'(REJECT_CYC) && hi_cnt_q < CW'(ACCEPT_CYC));
  end
endmodule

// File: rtl/sec_wipe_seq.sv
module sec_wipe_seq
  import sec_lock_pkg::*;
#(
  parameter int SRAM_AW     = 17,
  parameter int ERASE_WORDS = 32768,
  parameter int KILL_CYC    = 64
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               kill_req_i,
  input  logic               pool_full_i,
  output logic               busy_o,
  output logic               wipe_we_o,
  output logic [SRAM_AW-1:0] wipe_addr_o,
  output logic               gather_start_o,
  output logic               key_load_o,
  output logic               kill_o
);
  localparam int                 KW   = $clog2(KILL_CYC + 1);
  localparam logic [SRAM_AW-1:0] LAST = SRAM_AW'(ERASE_WORDS - 1);

  erase_st_e          st_q;
  logic [SRAM_AW-1:0] addr_q;
  logic [KW-1:0]      kill_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      addr_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          st_q   <= ST_WIPE;
          addr_q <= '0;
        end
        ST_WIPE: begin
          if (addr_q == LAST) st_q <= ST_SEED;
          else                addr_q <= addr_q + 1'b1;
        end
        ST_SEED: if (pool_full_i) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                   kill_q <= '0;
    else if (st_q == ST_IDLE && start_i && kill_req_i) kill_q <= KW'(KILL_CYC);
    else if (kill_q != '0)                         kill_q <= kill_q - 1'b1;
  end

  always_comb begin
    busy_o         = (st_q != ST_IDLE);
    wipe_we_o      = (st_q == ST_WIPE);
    wipe_addr_o    = addr_q;
    gather_start_o = (st_q == ST_WIPE) && (addr_q == LAST);
    key_load_o     = (st_q == ST_SEED) && pool_full_i;
    kill_o         = (kill_q != '0);
  end
endmodule

// File: rtl/sec_key_vault.sv
module sec_key_vault
  import sec_lock_pkg::*;
#(
  parameter int KEY_BYTES = 8,
  parameter int VEC_BYTES = 48,
  localparam int KEY_W  = KEY_BYTES * BYTE_W,
  localparam int VEC_AW = $clog2(VEC_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              gather_start_i,
  input  logic              session_start_i,
  input  logic              rnd_valid_i,
  input  logic [BYTE_W-1:0] rnd_byte_i,
  input  logic              key_load_i,
  input  logic              rekey_i,
  input  logic              vec_we_i,
  input  logic [VEC_AW-1:0] vec_waddr_i,
  input  logic [BYTE_W-1:0] vec_wdata_i,
  input  logic [VEC_AW-1:0] vec_raddr_i,
  output logic [KEY_W-1:0]  key_o,
  output logic [BYTE_W-1:0] vec_rdata_o,
  output logic              pool_full_o
);
  localparam int CW = $clog2(KEY_BYTES + 1);

  logic [KEY_W-1:0]  key_q, pool_q;
  logic [CW-1:0]     pool_cnt_q;
  logic              keyed_q;
  logic [BYTE_W-1:0] vec_q [VEC_BYTES];
  logic              rekey_ok;

  assign pool_full_o = (pool_cnt_q == CW'(KEY_BYTES));
  assign rekey_ok    = rekey_i && pool_full_o && !keyed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pool_q     <= '0;
      pool_cnt_q <= '0;
    end else begin
      if (rnd_valid_i) pool_q <= {pool_q[KEY_W-BYTE_W-1:0], rnd_byte_i};
      if (gather_start_i || session_start_i)        pool_cnt_q <= '0;
      else if (rnd_valid_i && !pool_full_o)        pool_cnt_q <= pool_cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      key_q   <= '0;
      keyed_q <= 1'b0;
    end else if (clear_i) begin
      key_q   <= '0;
    end else if (key_load_i || rekey_ok) begin
      key_q   <= pool_q;
      keyed_q <= 1'b1;
    end else if (session_start_i) begin
      keyed_q <= 1'b0;
    end
  end

  for (genvar g = 0; g < VEC_BYTES; g++) begin : g_vec
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                       vec_q[g] <= '0;
      else if (clear_i)                                  vec_q[g] <= '0;
      else if (vec_we_i && vec_waddr_i == VEC_AW'(g))    vec_q[g] <= vec_wdata_i;
    end
  end

  always_comb begin
    vec_rdata_o = '0;
    if (int'(vec_raddr_i) < VEC_BYTES) vec_rdata_o = vec_q[vec_raddr_i];
  end

  assign key_o = key_q;
endmodule

// File: rtl/sec_lock_ctrl.sv
module sec_lock_ctrl
  import sec_lock_pkg::*;
#(
  parameter int KEY_BYTES   = 8,
  parameter int VEC_BYTES   = 48,
  parameter int SRAM_AW     = 17,
  parameter int ERASE_WORDS = 32768,
  parameter int REJECT_CYC  = 4,
  parameter int ACCEPT_CYC  = 16,
  parameter int KILL_CYC    = 64,
  localparam int KEY_W  = KEY_BYTES * BYTE_W,
  localparam int VEC_AW = $clog2(VEC_BYTES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               lock_req_i,
  input  logic               unlock_req_i,
  input  logic               sdi_i,
  input  logic               session_start_i,
  input  logic               rekey_req_i,
  input  logic               rnd_valid_i,
  input  logic [BYTE_W-1:0]  rnd_byte_i,
  input  logic               vec_we_i,
  input  logic [VEC_AW-1:0]  vec_waddr_i,
  input  logic [BYTE_W-1:0]  vec_wdata_i,
  input  logic [VEC_AW-1:0]  vec_raddr_i,
  output logic [BYTE_W-1:0]  vec_rdata_o,
  input  logic               ld_req_i,
  input  logic               ld_we_i,
  input  logic [SRAM_AW-1:0] ld_addr_i,
  input  logic [BYTE_W-1:0]  ld_wdata_i,
  output logic [BYTE_W-1:0]  ld_rdata_o,
  output logic               sram_cs_o,
  output logic               sram_we_o,
  output logic [SRAM_AW-1:0] sram_addr_o,
  output logic [BYTE_W-1:0]  sram_wdata_o,
  input  logic [BYTE_W-1:0]  sram_rdata_i,
  output logic               supply_kill_o,
  output logic               lock_o,
  output logic               busy_o,
  output logic               access_o,
  output logic [KEY_W-1:0]   key_o
);
  logic               sdi_trig, trigger, lock_q;
  logic               busy, wipe_we, gather_start, key_load, pool_full;
  logic [SRAM_AW-1:0] wipe_addr;
  logic               idle_open;

  sec_sdi_filter #(
    .REJECT_CYC(REJECT_CYC),
    .ACCEPT_CYC(ACCEPT_CYC)
  ) u_sdi (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sdi_i (sdi_i),
    .trig_o(sdi_trig)
  );

  assign trigger   = !busy && (unlock_req_i || sdi_trig);
  assign idle_open = !busy && !lock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  lock_q <= 1'b0;
    else if (trigger)             lock_q <= 1'b0;
    else if (lock_req_i && !busy) lock_q <= 1'b1;
  end

  sec_wipe_seq #(
    .SRAM_AW    (SRAM_AW),
    .ERASE_WORDS(ERASE_WORDS),
    .KILL_CYC   (KILL_CYC)
  ) u_seq (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .start_i       (trigger),
    .kill_req_i    (sdi_trig),
    .pool_full_i   (pool_full),
    .busy_o        (busy),
    .wipe_we_o     (wipe_we),
    .wipe_addr_o   (wipe_addr),
    .gather_start_o(gather_start),
    .key_load_o    (key_load),
    .kill_o        (supply_kill_o)
  );

  sec_key_vault #(
    .KEY_BYTES(KEY_BYTES),
    .VEC_BYTES(VEC_BYTES)
  ) u_vault (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .clear_i        (trigger),
    .gather_start_i (gather_start),
    .session_start_i(session_start_i && !busy),
    .rnd_valid_i    (rnd_valid_i),
    .rnd_byte_i     (rnd_byte_i),
    .key_load_i     (key_load),
    .rekey_i        (rekey_req_i && idle_open),
    .vec_we_i       (vec_we_i && idle_open),
    .vec_waddr_i    (vec_waddr_i),
    .vec_wdata_i    (vec_wdata_i),
    .vec_raddr_i    (vec_raddr_i),
    .key_o          (key_o),
    .vec_rdata_o    (vec_rdata_o),
    .pool_full_o    (pool_full)
  );

  // erase engine owns the SRAM port while busy; loader only when open
  always_comb begin
    sram_cs_o    = 1'b0;
    sram_we_o    = 1'b0;
    sram_addr_o  = '0;
    sram_wdata_o = '0;
    ld_rdata_o   = '0;
    if (busy) begin
      sram_cs_o   = wipe_we;
      sram_we_o   = wipe_we;
      sram_addr_o = wipe_addr;
    end else if (!lock_q) begin
      sram_cs_o    = ld_req_i;
      sram_we_o    = ld_req_i && ld_we_i;
      sram_addr_o  = ld_addr_i;
      sram_wdata_o = ld_wdata_i;
      ld_rdata_o   = sram_rdata_i;
    end
  end

  assign lock_o   = lock_q;
  assign busy_o   = busy;
  assign access_o = idle_open;
endmodule

// File: rtl/sec_lock_ctrl_chk.sv
module sec_lock_ctrl_chk #(
  parameter int SRAM_AW = 17,
  parameter int KEY_W   = 64
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               busy_o,
  input logic               lock_o,
  input logic               access_o,
  input logic               supply_kill_o,
  input logic [KEY_W-1:0]   key_o,
  input logic [7:0]         vec_rdata_o,
  input logic [7:0]         ld_rdata_o,
  input logic               sram_cs_o,
  input logic               sram_we_o,
  input logic [SRAM_AW-1:0] sram_addr_o,
  input logic [7:0]         sram_wdata_o
);
  p_instant_clear_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> (key_o == '0) && !lock_o && (vec_rdata_o == '0));

  p_wipe_start_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> sram_cs_o && (sram_addr_o == '0));

  p_wipe_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && sram_cs_o) |-> sram_we_o && (sram_wdata_o == '0));

  p_wipe_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && sram_cs_o && $past(busy_o && sram_cs_o))
      |-> sram_addr_o == SRAM_AW'($past(sram_addr_o) + 1'b1));

  p_kill_in_busy_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    supply_kill_o |-> busy_o);

  p_lock_refuse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_o |-> !sram_cs_o && !access_o && (ld_rdata_o == '0));

  p_no_relock_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !lock_o);
endmodule

bind sec_lock_ctrl sec_lock_ctrl_chk #(
  .SRAM_AW(SRAM_AW),
  .KEY_W  (KEY_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .busy_o       (busy_o),
  .lock_o       (lock_o),
  .access_o     (access_o),
  .supply_kill_o(supply_kill_o),
  .key_o        (key_o),
  .vec_rdata_o  (vec_rdata_o),
  .ld_rdata_o   (ld_rdata_o),
  .sram_cs_o    (sram_cs_o),
  .sram_we_o    (sram_we_o),
  .sram_addr_o  (sram_addr_o),
  .sram_wdata_o (sram_wdata_o)
);

// File: tb/tb_sec_lock_ctrl.sv
module tb_sec_lock_ctrl;
  localparam int EW   = 64;
  localparam int KILL = 5;
  localparam int AW   = 17;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        lock_req_i = 0, unlock_req_i = 0, sdi_i = 0;
  logic        session_start_i = 0, rekey_req_i = 0, rnd_valid_i = 0;
  logic [7:0]  rnd_byte_i = 0;
  logic        vec_we_i = 0;
  logic [5:0]  vec_waddr_i = 0, vec_raddr_i = 6'd5;
  logic [7:0]  vec_wdata_i = 0, vec_rdata_o;
  logic        ld_req_i = 0, ld_we_i = 0;
  logic [AW-1:0] ld_addr_i = 0, sram_addr_o;
  logic [7:0]  ld_wdata_i = 0, ld_rdata_o, sram_wdata_o;
  logic [7:0]  sram_rdata_i = 8'h5A;
  logic        sram_cs_o, sram_we_o, supply_kill_o, lock_o, busy_o, access_o;
  logic [63:0] key_o;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  sec_lock_ctrl #(
    .SRAM_AW(AW), .ERASE_WORDS(EW), .REJECT_CYC(3), .ACCEPT_CYC(6), .KILL_CYC(KILL)
  ) dut (
    .clk_i(clk), .rst_ni(rst_ni), .lock_req_i(lock_req_i), .unlock_req_i(unlock_req_i),
    .sdi_i(sdi_i), .session_start_i(session_start_i), .rekey_req_i(rekey_req_i),
    .rnd_valid_i(rnd_valid_i), .rnd_byte_i(rnd_byte_i), .vec_we_i(vec_we_i),
    .vec_waddr_i(vec_waddr_i), .vec_wdata_i(vec_wdata_i), .vec_raddr_i(vec_raddr_i),
    .vec_rdata_o(vec_rdata_o), .ld_req_i(ld_req_i), .ld_we_i(ld_we_i),
    .ld_addr_i(ld_addr_i), .ld_wdata_i(ld_wdata_i), .ld_rdata_o(ld_rdata_o),
    .sram_cs_o(sram_cs_o), .sram_we_o(sram_we_o), .sram_addr_o(sram_addr_o),
    .sram_wdata_o(sram_wdata_o), .sram_rdata_i(sram_rdata_i),
    .supply_kill_o(supply_kill_o), .lock_o(lock_o), .busy_o(busy_o),
    .access_o(access_o), .key_o(key_o)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input logic ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic feed_bytes(input logic [63:0] v);
    for (int i = 7; i >= 0; i--) begin
      rnd_valid_i = 1'b1;
      rnd_byte_i  = v[i*8 +: 8];
      tick();
    end
    rnd_valid_i = 1'b0;
  endtask

  task automatic t_reset();
    chk(lock_o == 0 && busy_o == 0 && supply_kill_o == 0, "R1 flags", {61'd0, lock_o, busy_o, supply_kill_o}, 0);
    chk(key_o == 0, "R1 key", key_o, 0);
    chk(access_o == 1, "R1 access", access_o, 1);
    chk(vec_rdata_o == 0, "R1 vec", vec_rdata_o, 0);
  endtask

  task automatic t_loader_pass();
    ld_req_i = 1; ld_we_i = 1; ld_addr_i = 17'h01234; ld_wdata_i = 8'h77;
    #1;
    chk(sram_cs_o && sram_we_o && sram_addr_o == 17'h01234 && sram_wdata_o == 8'h77,
        "R11 write pass", {sram_cs_o, sram_we_o, sram_addr_o, sram_wdata_o}, 1);
    ld_we_i = 0;
    #1;
    chk(sram_cs_o && !sram_we_o && ld_rdata_o == 8'h5A, "R11 read pass", ld_rdata_o, 8'h5A);
    ld_req_i = 0;
    tick();
  endtask

  task automatic t_vec();
    vec_we_i = 1; vec_waddr_i = 6'd5; vec_wdata_i = 8'hAA;
    tick();
    vec_we_i = 0;
    vec_raddr_i = 6'd5;
    #1;
    chk(vec_rdata_o == 8'hAA, "R10 vec write", vec_rdata_o, 8'hAA);
  endtask

  task automatic t_rekey();
    session_start_i = 1; tick(); session_start_i = 0;
    feed_bytes(64'h0102030405060708);
    rekey_req_i = 1; tick(); rekey_req_i = 0;
    chk(key_o == 64'h0102030405060708, "R9 first rekey", key_o, 64'h0102030405060708);
    feed_bytes(64'hF1F2F3F4F5F6F7F8);
    rekey_req_i = 1; tick(); rekey_req_i = 0;
    chk(key_o == 64'h0102030405060708, "R9 key held in session", key_o, 64'h0102030405060708);
    session_start_i = 1; tick(); session_start_i = 0;
    feed_bytes(64'h1122334455667788);
    rekey_req_i = 1; tick(); rekey_req_i = 0;
    chk(key_o == 64'h1122334455667788, "R9 new session rekey", key_o, 64'h1122334455667788);
  endtask

  task automatic t_lock();
    lock_req_i = 1; tick(); lock_req_i = 0;
    chk(lock_o == 1 && access_o == 0, "R7 lock set", {lock_o, access_o}, 2'b10);
    ld_req_i = 1; ld_we_i = 1; ld_addr_i = 17'h00010;
    #1;
    chk(!sram_cs_o && ld_rdata_o == 0, "R7 loader refused", {sram_cs_o, ld_rdata_o}, 0);
    ld_req_i = 0; ld_we_i = 0;
    vec_we_i = 1; vec_waddr_i = 6'd5; vec_wdata_i = 8'h33;
    tick();
    vec_we_i = 0;
    chk(vec_rdata_o == 8'hAA, "R10 vec write refused when locked", vec_rdata_o, 8'hAA);
    session_start_i = 1; tick(); session_start_i = 0;
    feed_bytes(64'hDEADBEEFDEADBEEF);
    rekey_req_i = 1; tick(); rekey_req_i = 0;
    chk(key_o == 64'h1122334455667788, "R9 rekey refused when locked", key_o, 64'h1122334455667788);
  endtask

  // expects busy to rise within 20 cycles; walks the full erase chain
  task automatic run_erase(input logic exp_kill, input logic inject, input logic [63:0] seed);
    int n = 0;
    while (!busy_o && n < 20) begin tick(); n++; end
    sdi_i = 0;
    chk(busy_o == 1, "R2 busy raised", busy_o, 1);
    chk(key_o == 0 && lock_o == 0 && vec_rdata_o == 0, "R2 instant clear",
        {key_o[55:0], lock_o, vec_rdata_o[6:0]}, 0);
    for (int i = 0; i < EW; i++) begin
      chk(sram_cs_o && sram_we_o && sram_addr_o == AW'(i) && sram_wdata_o == 0,
          "R3 wipe step", {sram_cs_o, sram_we_o, sram_addr_o, sram_wdata_o}, i);
      chk(supply_kill_o == (exp_kill && i < KILL), "R6 kill window", supply_kill_o,
          exp_kill && i < KILL);
      if (inject && i == 8) begin lock_req_i = 1; unlock_req_i = 1; sdi_i = 1; end
      if (inject && i == 9) begin lock_req_i = 0; unlock_req_i = 0; end
      if (inject && i == 20) sdi_i = 0;
      if (inject && i > 8) chk(lock_o == 0, "R8 no relock", lock_o, 0);
      tick();
    end
    chk(busy_o == 1 && !sram_cs_o && !supply_kill_o, "R8 chain continues",
        {busy_o, sram_cs_o, supply_kill_o}, 3'b100);
    feed_bytes(seed);
    n = 0;
    while (busy_o && n < 5) begin tick(); n++; end
    chk(!busy_o && key_o == seed, "R4 new key", key_o, seed);
    chk(lock_o == 0 && access_o == 1, "R8 ends unlocked", {lock_o, access_o}, 1);
  endtask

  task automatic t_unlock();
    unlock_req_i = 1; tick(); unlock_req_i = 0;
    run_erase(1'b0, 1'b0, 64'hA1B2C3D4E5F60718);
  endtask

  task automatic t_sdi_short();
    sdi_i = 1; tick(); tick(); sdi_i = 0;
    for (int i = 0; i < 15; i++) tick();
    chk(!busy_o && !supply_kill_o && key_o == 64'hA1B2C3D4E5F60718, "R5 short pulse ignored",
        {busy_o, supply_kill_o}, 0);
  endtask

  task automatic t_sdi_long();
    sdi_i = 1;
    run_erase(1'b1, 1'b1, 64'h0F1E2D3C4B5A6978);
    for (int i = 0; i < 10; i++) tick();
    chk(!busy_o && !supply_kill_o, "R8 sdi during busy absorbed", {busy_o, supply_kill_o}, 0);
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    tick(); tick();
    rst_ni = 1'b1;
    tick();
    t_reset();
    t_loader_pass();
    t_vec();
    t_rekey();
    t_lock();
    t_unlock();
    t_sdi_short();
    t_sdi_long();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule